// File: doc/BRIEF.md
# Byte-Erasable Nonvolatile Array Model

A synthesizable behavioural model of a small byte-wide memory that can be rewritten many times, with the same asymmetric write rules as the real storage. A program pulse can only turn stored ones into zeros. A separate erase pulse returns a whole byte to all ones. A write has an effect only if its pulse is held for a minimum number of clock cycles. The model checks the rules a host controller must follow and reports each breach on its own flag. The rules are: a minimum pulse length, address and data that do not move during a pulse, and a chip-select release between two writes.

The host selects an operation with a 5-bit mode field and four active-low strobes. Reads return one byte per clock, with a valid bit and a corruption marker. An abort input cancels a write in progress and marks the targeted byte as having undefined contents. In standby or sleep the read port presents a fixed filler byte with the valid bit low. Test-mode codes are recognised and reported as unsupported. The model holds no analog timing, endurance or retention behaviour.

Top module: `nvm_byte_array`

## Requirements
- R1: With `mode_sel`=5'h00, `cs_n`=0, `sleep_n`=1 and `abort_n`=1, the strobes decode to one operation. Read is `we_n`,`prog_n`,`erase_n` = 1,1,1. Program is 0,0,1. Erase is 0,1,0. Any other strobe combination does nothing.
- R2: A program pulse that completes stores the old byte ANDed with `wdata`, so no bit ever goes from 0 to 1.
- R3: An erase pulse that completes stores 8'hFF whatever the value of `wdata`, and it clears the corruption marker of that byte.
- R4: If `addr`, or `wdata` during a program, differs from its value at the start of the pulse, `moved_err` rises and the byte is left unchanged.
- R5: Once a write has started, a second write is refused until `cs_n` has been high for at least one clock. A refused write sets `seq_err` and leaves the array unchanged.
- R6: Driving `abort_n` low ends a write in progress at the next edge without writing it, and marks the target byte as corrupted. Later reads of that byte show `rd_corrupt`=1 until an erase completes.
- R7: While `cs_n`=1 or `sleep_n`=0, the next output cycle shows `rdata_valid`=0 and `rdata`=INVALID_BYTE (default 8'hA5).
- R8: A write pulse held for fewer than MIN_PULSE clock edges leaves the byte unchanged and sets `short_err`. A pulse of exactly MIN_PULSE edges takes effect.
- R9: Mode codes 5'h01, 5'h02 and 5'h11 with the part selected set `unsupported` one cycle later, and they never change the array.
- R10: After `rst`, every byte reads 8'hFF with `rd_corrupt`=0, and all error flags are 0.
- R11: A read presented before a clock edge gives its byte, `rdata_valid`=1 and the corruption marker right after that edge. A byte written by a completed pulse is visible to the next read.
- R12: `short_err`, `moved_err` and `seq_err` stay set until the next write is accepted or until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; returns the array to all ones |
| mode_sel | input | 5 | Operation group select |
| addr | input | AW | Byte address, not latched by the host side |
| wdata | input | 8 | Program data |
| cs_n | input | 1 | Active-low select; high releases the write register |
| we_n | input | 1 | Active-low write strobe |
| prog_n | input | 1 | Active-low program key |
| erase_n | input | 1 | Active-low erase key |
| abort_n | input | 1 | Active-low abort; cancels a write in progress |
| sleep_n | input | 1 | Active-low sleep |
| rdata | output | 8 | Read byte, or INVALID_BYTE when not valid |
| rdata_valid | output | 1 | Read byte is valid |
| rd_corrupt | output | 1 | Byte just read was hit by an aborted write |
| short_err | output | 1 | Last pulse was shorter than MIN_PULSE |
| moved_err | output | 1 | Address or data moved during a pulse |
| seq_err | output | 1 | Write refused because chip select was not released |
| unsupported | output | 1 | Test-mode code seen |

## Verification
The hardest state to reach is a byte marked corrupted. This needs a write already latched and counting, then an abort partway through the pulse. The stimulus starts a program pulse, holds it for a few cycles fewer than the minimum, and drops `abort_n` for one cycle. It then reads the byte, erases it, and reads it again to see the marker clear. A second state that is hard to reach is the refusal of a write that does not release chip select. The stimulus reaches it by keeping `cs_n` low across two back-to-back pulses.

// File: rtl/nvm_pkg.sv
`timescale 1ns/1ps
package nvm_pkg;
  localparam logic [4:0] MODE_MAIN   = 5'h00;
  localparam logic [4:0] MODE_TST_A  = 5'h01;
  localparam logic [4:0] MODE_TST_B  = 5'h02;
  localparam logic [4:0] MODE_TST_C  = 5'h11;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  function automatic logic is_test_code(input logic [4:0] m);
    return (m == MODE_TST_A) || (m == MODE_TST_B) || (m == MODE_TST_C);
  endfunction
endpackage

// File: rtl/nvm_cmd_decode.sv
`timescale 1ns/1ps
module nvm_cmd_decode
  import nvm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] mode_sel,
  input  logic       cs_n,
  input  logic       we_n,
  input  logic       prog_n,
  input  logic       erase_n,
  input  logic       abort_n,
  input  logic       sleep_n,
  output logic       is_read,
  output logic       is_prog,
  output logic       is_erase,
  output logic       is_test
);
  logic selected;
  logic main_grp;

  always_comb begin
    selected = !cs_n && sleep_n && abort_n;
    main_grp = selected && (mode_sel == MODE_MAIN);
    is_read  = main_grp &&  we_n &&  prog_n &&  erase_n;
    is_prog  = main_grp && !we_n && !prog_n &&  erase_n;
    is_erase = main_grp && !we_n &&  prog_n && !erase_n;
    is_test  = selected && is_test_code(mode_sel);
  end

  // R1: at most one operation is decoded in any cycle
  assert_single_op_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({is_read, is_prog, is_erase, is_test}));
endmodule

// File: rtl/nvm_write_ctrl.sv
`timescale 1ns/1ps
module nvm_write_ctrl
  import nvm_pkg::*;
#(
  parameter int AW        = 8,
  parameter int MIN_PULSE = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_prog,
  input  logic          is_erase,
  input  logic          cs_n,
  input  logic          abort_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic [7:0]    old_byte,
  output logic          busy,
  output logic [AW-1:0] lat_addr,
  output logic          wr_en,
  output logic          wr_erase,
  output logic [7:0]    wr_data,
  output logic          corrupt_req,
  output logic          short_err,
  output logic          moved_err,
  output logic          seq_err
);
  localparam int MIN_EFF = (MIN_PULSE < 2) ? 2 : MIN_PULSE;
  localparam int CW      = $clog2(MIN_EFF + 1);
  localparam logic [CW-1:0] CNT_MIN = CW'(MIN_EFF);

  logic [CW-1:0] cnt;
  logic [7:0]    lat_data;
  logic          lat_erase;
  logic          used;
  logic          moved_q;
  logic          any_wr;
  logic          same_kind;
  logic          moved_now;
  logic          pulse_end;
  logic          long_enough;
  logic          start;
  logic          reject;

  always_comb begin
    any_wr      = is_prog || is_erase;
    same_kind   = busy && (lat_erase ? is_erase : is_prog);
    moved_now   = same_kind && ((addr != lat_addr) ||
                  (!lat_erase && (wdata != lat_data)));
    pulse_end   = busy && abort_n && !same_kind;
    long_enough = (cnt >= CNT_MIN);
    start       = !busy && abort_n && any_wr && !used;
    reject      = !busy && abort_n && any_wr &&  used;
    wr_en       = pulse_end && long_enough && !moved_q;
    wr_erase    = lat_erase;
    wr_data     = lat_erase ? ERASED_BYTE : (old_byte & lat_data);
    corrupt_req = busy && !abort_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      used      <= 1'b0;
      cnt       <= '0;
      lat_addr  <= '0;
      lat_data  <= '0;
      lat_erase <= 1'b0;
      moved_q   <= 1'b0;
      short_err <= 1'b0;
      moved_err <= 1'b0;
      seq_err   <= 1'b0;
    end else begin
      if (!abort_n || cs_n) used <= 1'b0;
      else if (start)       used <= 1'b1;

      if (!abort_n)       busy <= 1'b0;
      else if (start)     busy <= 1'b1;
      else if (pulse_end) busy <= 1'b0;

      if (start) begin
        cnt       <= CW'(1);
        lat_addr  <= addr;
        lat_data  <= wdata;
        lat_erase <= is_erase;
        moved_q   <= 1'b0;
        short_err <= 1'b0;
        moved_err <= 1'b0;
        seq_err   <= 1'b0;
      end else begin
        if (same_kind && (cnt < CNT_MIN)) cnt <= cnt + CW'(1);
        if (moved_now) begin
          moved_q   <= 1'b1;
          moved_err <= 1'b1;
        end
        if (pulse_end && !long_enough) short_err <= 1'b1;
        if (reject) seq_err <= 1'b1;
      end
    end
  end

  // R6: an abort always leaves the controller idle
  assert_abort_idles_R6: assert property (@(posedge clk) disable iff (rst)
    !abort_n |=> !busy);
  // R5: a refusal can only follow a cycle with chip select held low
  assert_reject_needs_low_cs_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_err) |-> !$past(cs_n));
  // R4: a pulse that reported movement never commits
  assert_no_commit_after_move_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !moved_err);
endmodule

// File: rtl/nvm_store.sv
`timescale 1ns/1ps
module nvm_store
  import nvm_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic          wr_erase,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          corrupt_req,
  input  logic [AW-1:0] corrupt_addr,
  output logic [7:0]    old_byte,
  output logic          old_corrupt
);
  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] written;
  logic [DEPTH-1:0] damaged;
  logic [7:0]       mem_q;
  logic             written_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    mem_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written     <= '0;
      damaged     <= '0;
      written_q   <= 1'b0;
      old_corrupt <= 1'b0;
    end else begin
      written_q   <= written[rd_addr];
      old_corrupt <= damaged[rd_addr];
      if (wr_en) begin
        written[wr_addr] <= 1'b1;
        if (wr_erase) damaged[wr_addr] <= 1'b0;
      end
      if (corrupt_req) damaged[corrupt_addr] <= 1'b1;
    end
  end

  always_comb old_byte = written_q ? mem_q : ERASED_BYTE;

  // R2: a program commit never raises a bit that is stored as zero
  assert_prog_only_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_erase) |-> ((wr_data & ~old_byte) == 8'h00));
  // R3: an erase commit writes all ones
  assert_erase_all_ones_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_erase) |-> (wr_data == ERASED_BYTE));
endmodule

// File: rtl/nvm_byte_array.sv
`timescale 1ns/1ps
module nvm_byte_array
  import nvm_pkg::*;
#(
  parameter int         DEPTH        = 256,
  parameter int         MIN_PULSE    = 8,
  parameter logic [7:0] INVALID_BYTE = 8'hA5,
  localparam int        AW           = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    mode_sel,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          prog_n,
  input  logic          erase_n,
  input  logic          abort_n,
  input  logic          sleep_n,
  output logic [7:0]    rdata,
  output logic          rdata_valid,
  output logic          rd_corrupt,
  output logic          short_err,
  output logic          moved_err,
  output logic          seq_err,
  output logic          unsupported
);
  logic          is_read, is_prog, is_erase, is_test;
  logic          busy;
  logic [AW-1:0] lat_addr;
  logic          wr_en, wr_erase, corrupt_req;
  logic [7:0]    wr_data;
  logic [7:0]    old_byte;
  logic          old_corrupt;
  logic [AW-1:0] rd_addr;
  logic          rd_q;

  nvm_cmd_decode u_dec (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .cs_n(cs_n), .we_n(we_n),
    .prog_n(prog_n), .erase_n(erase_n), .abort_n(abort_n), .sleep_n(sleep_n),
    .is_read(is_read), .is_prog(is_prog), .is_erase(is_erase), .is_test(is_test)
  );

  nvm_write_ctrl #(.AW(AW), .MIN_PULSE(MIN_PULSE)) u_wctl (
    .clk(clk), .rst(rst), .is_prog(is_prog), .is_erase(is_erase),
    .cs_n(cs_n), .abort_n(abort_n), .addr(addr), .wdata(wdata),
    .old_byte(old_byte), .busy(busy), .lat_addr(lat_addr), .wr_en(wr_en),
    .wr_erase(wr_erase), .wr_data(wr_data), .corrupt_req(corrupt_req),
    .short_err(short_err), .moved_err(moved_err), .seq_err(seq_err)
  );

  always_comb rd_addr = busy ? lat_addr : addr;

  nvm_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_erase(wr_erase), .wr_addr(lat_addr), .wr_data(wr_data),
    .corrupt_req(corrupt_req), .corrupt_addr(lat_addr),
    .old_byte(old_byte), .old_corrupt(old_corrupt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q        <= 1'b0;
      unsupported <= 1'b0;
    end else begin
      rd_q        <= is_read;
      unsupported <= is_test;
    end
  end

  always_comb begin
    rdata_valid = rd_q;
    rdata       = rd_q ? old_byte : INVALID_BYTE;
    rd_corrupt  = rd_q && old_corrupt;
  end

  // R7: standby or sleep gives an invalid read in the following cycle
  assert_standby_invalid_R7: assert property (@(posedge clk) disable iff (rst)
    (cs_n || !sleep_n) |=> !rdata_valid);
  // R9: a test-mode code never starts a write pulse
  assert_test_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    is_test |=> !$rose(busy));
endmodule

// File: tb/nvm_byte_array_bench.sv
`timescale 1ns/1ps
module nvm_byte_array_bench;
  localparam int DEPTH = 256;
  localparam int MINP  = 8;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] mode_sel = 5'h00;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = 8'h00;
  logic cs_n = 1'b1, we_n = 1'b1, prog_n = 1'b1, erase_n = 1'b1;
  logic abort_n = 1'b1, sleep_n = 1'b1;
  logic [7:0] rdata;
  logic rdata_valid, rd_corrupt, short_err, moved_err, seq_err, unsupported;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  nvm_byte_array #(.DEPTH(DEPTH), .MIN_PULSE(MINP)) u_nvm_byte_array (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .addr(addr), .wdata(wdata),
    .cs_n(cs_n), .we_n(we_n), .prog_n(prog_n), .erase_n(erase_n),
    .abort_n(abort_n), .sleep_n(sleep_n), .rdata(rdata),
    .rdata_valid(rdata_valid), .rd_corrupt(rd_corrupt), .short_err(short_err),
    .moved_err(moved_err), .seq_err(seq_err), .unsupported(unsupported)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic strobes_off();
    we_n = 1'b1; prog_n = 1'b1; erase_n = 1'b1;
  endtask

  task automatic release_cs();
    @(negedge clk); strobes_off(); cs_n = 1'b1; mode_sel = 5'h00;
  endtask

  task automatic read_chk(input string req, input int a, input int exp, input int exp_cor);
    @(negedge clk);
    cs_n = 1'b0; mode_sel = 5'h00; strobes_off(); addr = AW'(a);
    @(posedge clk); @(negedge clk);
    chk(req, "read valid", int'(rdata_valid), 1);
    chk(req, "read data", int'(rdata), exp);
    chk(req, "read corrupt", int'(rd_corrupt), exp_cor);
  endtask

  // full pulse, ends with strobes released while still selected
  task automatic pulse(input bit er, input int a, input int d, input int len);
    release_cs();
    @(negedge clk);
    cs_n = 1'b0; addr = AW'(a); wdata = 8'(d);
    we_n = 1'b0; prog_n = er; erase_n = !er;
    repeat (len) @(posedge clk);
    @(negedge clk); strobes_off();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10", "short_err", int'(short_err), 0);
    chk("R10", "moved_err", int'(moved_err), 0);
    chk("R10", "seq_err", int'(seq_err), 0);
    read_chk("R10", 0, 8'hFF, 0);
    read_chk("R10", DEPTH-1, 8'hFF, 0);
  endtask

  task automatic t_program();
    pulse(1'b0, 3, 8'h3C, MINP + 2);
    chk("R12", "short_err after good pulse", int'(short_err), 0);
    read_chk("R1 R11", 3, 8'h3C, 0);
    pulse(1'b0, 3, 8'hF3, MINP);
    read_chk("R2", 3, 8'h30, 0);
  endtask

  task automatic t_erase();
    pulse(1'b1, 3, 8'h00, MINP);
    read_chk("R3", 3, 8'hFF, 0);
  endtask

  task automatic t_short();
    pulse(1'b0, 5, 8'h00, MINP - 1);
    chk("R8", "short_err", int'(short_err), 1);
    read_chk("R8", 5, 8'hFF, 0);
    chk("R12", "short_err held", int'(short_err), 1);
    pulse(1'b0, 5, 8'h81, MINP);
    chk("R12", "short_err cleared", int'(short_err), 0);
    read_chk("R8", 5, 8'h81, 0);
  endtask

  task automatic t_moved();
    release_cs();
    @(negedge clk);
    cs_n = 1'b0; addr = AW'(6); wdata = 8'h0F; we_n = 1'b0; prog_n = 1'b0;
    @(posedge clk); @(negedge clk); addr = AW'(7);
    repeat (MINP) @(posedge clk);
    @(negedge clk); strobes_off();
    @(posedge clk); @(negedge clk);
    chk("R4", "moved_err addr", int'(moved_err), 1);
    read_chk("R4", 6, 8'hFF, 0);
    read_chk("R4", 7, 8'hFF, 0);
    release_cs();
    @(negedge clk);
    cs_n = 1'b0; addr = AW'(7); wdata = 8'h0F; we_n = 1'b0; prog_n = 1'b0;
    @(posedge clk); @(negedge clk); wdata = 8'h00;
    repeat (MINP) @(posedge clk);
    @(negedge clk); strobes_off();
    @(posedge clk); @(negedge clk);
    chk("R4", "moved_err data", int'(moved_err), 1);
    read_chk("R4", 7, 8'hFF, 0);
  endtask

  task automatic t_sequence();
    pulse(1'b0, 8, 8'h55, MINP);
    @(negedge clk);
    addr = AW'(9); wdata = 8'h00; we_n = 1'b0; prog_n = 1'b0;
    repeat (MINP) @(posedge clk);
    @(negedge clk); strobes_off();
    @(posedge clk); @(negedge clk);
    chk("R5", "seq_err", int'(seq_err), 1);
    release_cs();
    read_chk("R5", 9, 8'hFF, 0);
    read_chk("R5", 8, 8'h55, 0);
  endtask

  task automatic t_abort();
    release_cs();
    @(negedge clk);
    cs_n = 1'b0; addr = AW'(10); wdata = 8'h00; we_n = 1'b0; prog_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); abort_n = 1'b0;
    @(posedge clk); @(negedge clk); abort_n = 1'b1; strobes_off();
    release_cs();
    read_chk("R6", 10, 8'hFF, 1);
    pulse(1'b1, 10, 8'h12, MINP);
    read_chk("R6", 10, 8'hFF, 0);
  endtask

  task automatic t_standby();
    @(negedge clk); cs_n = 1'b1; strobes_off(); addr = AW'(3);
    @(posedge clk); @(negedge clk);
    chk("R7", "standby valid", int'(rdata_valid), 0);
    chk("R7", "standby data", int'(rdata), 8'hA5);
    cs_n = 1'b0; sleep_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R7", "sleep valid", int'(rdata_valid), 0);
    chk("R7", "sleep data", int'(rdata), 8'hA5);
    sleep_n = 1'b1;
  endtask

  task automatic t_testmode();
    logic [4:0] codes [3] = '{5'h01, 5'h02, 5'h11};
    for (int i = 0; i < 3; i++) begin
      release_cs();
      @(negedge clk);
      cs_n = 1'b0; mode_sel = codes[i]; addr = AW'(12); wdata = 8'h00;
      we_n = 1'b0; prog_n = 1'b0;
      repeat (MINP) @(posedge clk);
      @(negedge clk);
      chk("R9", "unsupported", int'(unsupported), 1);
      strobes_off(); mode_sel = 5'h00;
      @(posedge clk); @(negedge clk);
      chk("R9", "unsupported drops", int'(unsupported), 0);
    end
    release_cs();
    read_chk("R9", 12, 8'hFF, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_program();
    t_erase();
    t_short();
    t_moved();
    t_sequence();
    t_abort();
    t_standby();
    t_testmode();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule